// File: doc/BRIEF.md
# Receive Frame Rule Classifier

This block sorts each received Ethernet frame into a return ring. It can also decide to drop the frame. Frame bytes stream in one per beat, with start-of-frame and end-of-frame markers on the first and last beat. The VLAN tag has already been stripped when the bytes arrive.

A table of host-written rules is checked against every frame. Each rule has a 32-bit control word and a 32-bit value/mask word. A rule pulls two or four bytes from a programmable position in the frame and compares them against its programmed operand. Rules are scanned from the lowest index to the highest, and the first rule, or AND-chain of rules, that matches decides the ring. When nothing matches, a programmable default ring is used, and a default of zero drops the frame.

Rules are read at the end of a frame. Software should only rewrite a rule while that rule is disabled, and should wait at least 20 clocks before re-enabling it. Rules that stay stable while enabled give defined results.

The register map has three kinds of entry:
- Address `2*i` holds the control word of rule `i`.
- Address `2*i+1` holds the value/mask word of rule `i`.
- Address `2*NRULES` (32 by default) holds the default-class register.

Top module: `rx_rule_classifier`

## Requirements
- R1: After reset, `v_valid` is low, every rule is disabled and the default class is 0. A frame sent before any register write is therefore dropped.
- R2: A verdict appears as a single-cycle `v_valid` pulse in the cycle right after the beat that carries `s_eof`. No other cycle has `v_valid` high.
- R3: A rule whose control bit 31 (enable) is 0 never matches, even if its field would compare true.
- R4: With control bit 26 clear, four bytes starting at the extraction position are joined into a word, with the first byte in bits 31:24. This word is compared against the whole value/mask word.
- R5: With control bit 26 set, two bytes are extracted, with the first byte in bits 15:8. Both the extracted field and value/mask bits 15:0 are ANDed with the mask in value/mask bits 31:16 before the compare.
- R6: Control bits 17:16 pick the compare operator, applied as "extracted OP operand", unsigned. The encodings are 0 equal, 1 not-equal, 2 greater-than and 3 less-than.
- R7: Control bits 7:0 are a byte offset. Control bits 14:13 pick the base the offset is added to:
  - 0 or 3: frame byte 0.
  - 1: byte 14, the IP header.
  - 2: byte 14 plus 4 times the low nibble of byte 14, the TCP/UDP header.
- R8: A rule with control bit 30 set is ANDed with the next rule. A chain yields the class of its last rule only when every rule in the chain is enabled and matches. If the last rule has bit 30 set, the chain ends there.
- R9: When several chains match, the one containing the lowest-indexed rule decides the ring.
- R10: If no chain matches, bits 7:3 of the default-class register give the ring. A value of 0 drops the frame.
- R11: If the frame ends before all bytes of a rule's extraction window have arrived, that rule counts as not matched.
- R12: A dropped frame has `v_drop`=1 and `v_ring`=0. A kept frame has `v_drop`=0 and `v_ring` between 1 and 16. A selected class of 0, or one above 16, drops the frame. Rule control bits 12:8 hold the class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register address |
| cfg_wdata | input | 32 | Register write data |
| s_valid | input | 1 | Frame byte valid |
| s_sof | input | 1 | First byte of frame |
| s_eof | input | 1 | Last byte of frame |
| s_data | input | 8 | Frame byte |
| v_valid | output | 1 | Verdict strobe |
| v_drop | output | 1 | Frame is discarded |
| v_ring | output | 5 | Selected ring, 0 when dropped |

## Verification
The bench builds the block with its default parameters: 16 rules, 16 rings, a 12-bit byte position and the IP header at byte 14. These defaults place the register map's top entry, the default class at address 32, inside the 6-bit address range. They also let 48-byte test frames reach the TCP/UDP header base of byte 34 for a 5-word IP header, and put a 32-bit window across the frame end at offset 46. Each rule's capture path is produced by the same generate loop, so rules 0 and 1 stand for the rest; priority and chaining are exercised across that pair.

// File: rtl/rx_cls_pkg.sv
package rx_cls_pkg;
  localparam int CLS_W = 5;

  typedef enum logic [1:0] {
    OP_EQ = 2'd0,
    OP_NE = 2'd1,
    OP_GT = 2'd2,
    OP_LT = 2'd3
  } cmp_op_e;

  typedef enum logic [1:0] {
    BASE_FRAME = 2'd0,
    BASE_IP    = 2'd1,
    BASE_L4    = 2'd2,
    BASE_ALT   = 2'd3
  } base_sel_e;

  // control word bit positions
  localparam int B_EN   = 31;
  localparam int B_AND  = 30;
  localparam int B_MODE = 26;
  localparam int B_OPLO = 16;
  localparam int B_HSLO = 13;
  localparam int B_CLLO = 8;
endpackage

// File: rtl/rx_rule_store.sv
module rx_rule_store #(
  parameter int NRULES = 16,
  parameter int AW     = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [AW-1:0]           addr,
  input  logic [31:0]             wdata,
  output logic [NRULES-1:0][31:0] ctl,
  output logic [NRULES-1:0][31:0] vm,
  output logic [4:0]              dflt
);
  localparam int DFLT_ADDR = 2 * NRULES;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl  <= '0;
      vm   <= '0;
      dflt <= '0;
    end else if (we) begin
      if (int'(addr) == DFLT_ADDR) begin
        dflt <= wdata[7:3];
      end else if (int'(addr) < DFLT_ADDR) begin
        if (addr[0]) vm[addr[AW-1:1]]  <= wdata;
        else         ctl[addr[AW-1:1]] <= wdata;
      end
    end
  end
endmodule

// File: rtl/rx_rule_lane.sv
module rx_rule_lane
  import rx_cls_pkg::*;
#(
  parameter int POS_W   = 12,
  parameter int IP_BASE = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             beat,
  input  logic             sof,
  input  logic [7:0]       data,
  input  logic [POS_W-1:0] pos,
  input  logic [POS_W-1:0] l4_base,
  input  logic [31:0]      ctl,
  input  logic [31:0]      vm,
  output logic             hit_nx
);
  logic [31:0]      cap_q, cap_b, cap_nx;
  logic [2:0]       cnt_q, cnt_b, cnt_nx, need;
  logic [POS_W-1:0] base, start, rel;
  logic             in_win;
  logic [31:0]      ext, opnd;
  logic             cmp;
  base_sel_e        hsel;
  cmp_op_e          op;

  assign hsel = base_sel_e'(ctl[B_HSLO +: 2]);
  assign op   = cmp_op_e'(ctl[B_OPLO +: 2]);
  assign need = ctl[B_MODE] ? 3'd2 : 3'd4;

  always_comb begin
    unique case (hsel)
      BASE_IP: base = POS_W'(IP_BASE);
      BASE_L4: base = l4_base;
      default: base = '0;
    endcase
    start  = base + POS_W'(ctl[7:0]);
    rel    = pos - start;
    in_win = beat && (pos >= start) && (rel < POS_W'(need));
    cap_b  = (beat && sof) ? '0 : cap_q;
    cnt_b  = (beat && sof) ? '0 : cnt_q;
    cap_nx = in_win ? {cap_b[23:0], data} : cap_b;
    cnt_nx = in_win ? cnt_b + 3'd1 : cnt_b;
    if (ctl[B_MODE]) begin
      ext  = {16'h0, cap_nx[15:0] & vm[31:16]};
      opnd = {16'h0, vm[15:0] & vm[31:16]};
    end else begin
      ext  = cap_nx;
      opnd = vm;
    end
    unique case (op)
      OP_EQ:   cmp = (ext == opnd);
      OP_NE:   cmp = (ext != opnd);
      OP_GT:   cmp = (ext > opnd);
      default: cmp = (ext < opnd);
    endcase
    hit_nx = ctl[B_EN] && (cnt_nx == need) && cmp;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q <= '0;
      cnt_q <= '0;
    end else begin
      cap_q <= cap_nx;
      cnt_q <= cnt_nx;
    end
  end
endmodule

// File: rtl/rx_chain_resolve.sv
module rx_chain_resolve
  import rx_cls_pkg::*;
#(
  parameter int NRULES = 16,
  parameter int NRINGS = 16
) (
  input  logic [NRULES-1:0]            hit,
  input  logic [NRULES-1:0]            and_f,
  input  logic [NRULES-1:0][CLS_W-1:0] cls,
  input  logic [CLS_W-1:0]             dflt,
  output logic                         drop,
  output logic [CLS_W-1:0]             ring
);
  logic             acc, found;
  logic [CLS_W-1:0] pick;

  always_comb begin
    acc   = 1'b1;
    found = 1'b0;
    pick  = dflt;
    for (int i = 0; i < NRULES; i++) begin
      acc = acc & hit[i];
      if (!and_f[i] || i == NRULES - 1) begin
        if (acc && !found) begin
          found = 1'b1;
          pick  = cls[i];
        end
        acc = 1'b1;
      end
    end
    drop = (pick == '0) || (int'(pick) > NRINGS);
    ring = drop ? '0 : pick;
  end
endmodule

// File: rtl/rx_rule_classifier.sv
module rx_rule_classifier
  import rx_cls_pkg::*;
#(
  parameter int NRULES  = 16,
  parameter int NRINGS  = 16,
  parameter int POS_W   = 12,
  parameter int IP_BASE = 14,
  localparam int AW     = $clog2(2 * NRULES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [31:0]      cfg_wdata,
  input  logic             s_valid,
  input  logic             s_sof,
  input  logic             s_eof,
  input  logic [7:0]       s_data,
  output logic             v_valid,
  output logic             v_drop,
  output logic [CLS_W-1:0] v_ring
);
  logic [NRULES-1:0][31:0]      ctl, vm;
  logic [CLS_W-1:0]             dflt;
  logic [NRULES-1:0]            hit, and_f;
  logic [NRULES-1:0][CLS_W-1:0] cls;
  logic [POS_W-1:0]             bcnt, pos, l4_base;
  logic [3:0]                   ihl_q, ihl_cur;
  logic                         drop_c;
  logic [CLS_W-1:0]             ring_c;

  rx_rule_store #(.NRULES(NRULES), .AW(AW)) u_store (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .ctl(ctl), .vm(vm), .dflt(dflt)
  );

  // byte position and header bases
  assign pos     = s_sof ? '0 : bcnt;
  assign ihl_cur = (s_valid && pos == POS_W'(IP_BASE)) ? s_data[3:0] : ihl_q;
  assign l4_base = POS_W'(IP_BASE) + {ihl_cur, 2'b00};

  always_ff @(posedge clk) begin
    if (rst) begin
      bcnt  <= '0;
      ihl_q <= '0;
    end else if (s_valid) begin
      if (pos != '1) bcnt <= pos + 1'b1;
      else           bcnt <= pos;
      ihl_q <= ihl_cur;
    end
  end

  for (genvar g = 0; g < NRULES; g++) begin : g_lane
    rx_rule_lane #(.POS_W(POS_W), .IP_BASE(IP_BASE)) u_lane (
      .clk(clk), .rst(rst), .beat(s_valid), .sof(s_sof), .data(s_data),
      .pos(pos), .l4_base(l4_base), .ctl(ctl[g]), .vm(vm[g]),
      .hit_nx(hit[g])
    );
    assign and_f[g] = ctl[g][B_AND];
    assign cls[g]   = ctl[g][B_CLLO +: CLS_W];
  end

  rx_chain_resolve #(.NRULES(NRULES), .NRINGS(NRINGS)) u_resolve (
    .hit(hit), .and_f(and_f), .cls(cls), .dflt(dflt),
    .drop(drop_c), .ring(ring_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      v_valid <= 1'b0;
      v_drop  <= 1'b0;
      v_ring  <= '0;
    end else begin
      v_valid <= s_valid && s_eof;
      if (s_valid && s_eof) begin
        v_drop <= drop_c;
        v_ring <= ring_c;
      end
    end
  end
endmodule

// File: rtl/rx_rule_classifier_chk.sv
module rx_rule_classifier_chk #(
  parameter int NRINGS = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       s_valid,
  input logic       s_eof,
  input logic       v_valid,
  input logic       v_drop,
  input logic [4:0] v_ring
);
  a_r2_eof_gives_verdict: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_eof) |=> v_valid);
  a_r2_verdict_needs_eof: assert property (@(posedge clk) disable iff (rst)
    v_valid |-> $past(s_valid && s_eof));
  a_r12_drop_ring_zero: assert property (@(posedge clk) disable iff (rst)
    (v_valid && v_drop) |-> (v_ring == 5'd0));
  a_r12_kept_ring_range: assert property (@(posedge clk) disable iff (rst)
    (v_valid && !v_drop) |-> (v_ring != 5'd0 && int'(v_ring) <= NRINGS));
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !v_valid);
endmodule

bind rx_rule_classifier rx_rule_classifier_chk #(.NRINGS(NRINGS)) u_chk (
  .clk(clk), .rst(rst), .s_valid(s_valid), .s_eof(s_eof),
  .v_valid(v_valid), .v_drop(v_drop), .v_ring(v_ring)
);

// File: tb/rx_rule_classifier_tb.sv
module rx_rule_classifier_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        s_valid = 1'b0, s_sof = 1'b0, s_eof = 1'b0;
  logic [7:0]  s_data = '0;
  logic        v_valid, v_drop;
  logic [4:0]  v_ring;
  logic [7:0]  fr [0:63];
  int          checks = 0, errors = 0;

  always #10 clk = ~clk;

  rx_rule_classifier u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .s_valid(s_valid), .s_sof(s_sof), .s_eof(s_eof),
    .s_data(s_data), .v_valid(v_valid), .v_drop(v_drop), .v_ring(v_ring)
  );

  function automatic logic [31:0] ctlw(input bit en, input bit andf,
      input bit m16, input int op, input int hs, input int cls, input int off);
    return {en, andf, 3'b0, m16, 8'b0, op[1:0], 1'b0, hs[1:0], cls[4:0], off[7:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 6'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clear_rules();
    for (int i = 0; i < 32; i++) wr(i, 32'h0);
  endtask

  task automatic rule(input int idx, input logic [31:0] c, input logic [31:0] v);
    wr(2 * idx + 1, v);
    wr(2 * idx, c);
  endtask

  // sends a frame of len bytes, then checks the verdict and its single-cycle width
  task automatic frame_check(input string req, input int len,
                             input bit exp_drop, input int exp_ring);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      s_valid = 1'b1; s_sof = (k == 0); s_eof = (k == len - 1); s_data = fr[k];
    end
    @(negedge clk);
    s_valid = 1'b0; s_sof = 1'b0; s_eof = 1'b0;
    chk({req, " valid"}, 32'(v_valid), 32'd1);
    chk({req, " drop"}, 32'(v_drop), 32'(exp_drop));
    chk({req, " ring"}, 32'(v_ring), 32'(exp_ring));
    @(negedge clk);
    chk({req, " R2 pulse"}, 32'(v_valid), 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 reset valid", 32'(v_valid), 32'd0);
    frame_check("R1 reset drop", 48, 1'b1, 0);
  endtask

  task automatic t_default();
    wr(32, 32'(3 << 3));
    frame_check("R10 default ring3", 48, 1'b0, 3);
    wr(32, 32'h0);
    frame_check("R10 default zero", 48, 1'b1, 0);
    wr(32, 32'(9 << 3));
  endtask

  task automatic t_full();
    rule(0, ctlw(1, 0, 0, 0, 0, 5, 2), 32'h02030405);
    frame_check("R4 full match", 48, 1'b0, 5);
    rule(0, ctlw(1, 0, 0, 0, 0, 5, 2), 32'h02030406);
    frame_check("R4 full miss", 48, 1'b0, 9);
    clear_rules();
  endtask

  task automatic t_disabled();
    rule(0, ctlw(0, 0, 0, 0, 0, 5, 2), 32'h02030405);
    frame_check("R3 disabled", 48, 1'b0, 9);
    clear_rules();
  endtask

  task automatic t_masked();
    rule(0, ctlw(1, 0, 1, 0, 0, 6, 6), 32'hFF00_0600);
    frame_check("R5 mask hit", 48, 1'b0, 6);
    rule(0, ctlw(1, 0, 1, 0, 0, 6, 6), 32'hFF00_0700);
    frame_check("R5 mask miss", 48, 1'b0, 9);
    rule(0, ctlw(1, 0, 1, 0, 0, 6, 6), 32'h00FF_0907);
    frame_check("R5 low mask", 48, 1'b0, 6);
    clear_rules();
  endtask

  task automatic t_ops();
    rule(0, ctlw(1, 0, 0, 1, 0, 4, 2), 32'h02030400);
    frame_check("R6 ne", 48, 1'b0, 4);
    rule(0, ctlw(1, 0, 0, 2, 0, 4, 2), 32'h02030400);
    frame_check("R6 gt", 48, 1'b0, 4);
    rule(0, ctlw(1, 0, 0, 3, 0, 4, 2), 32'h02030400);
    frame_check("R6 lt false", 48, 1'b0, 9);
    rule(0, ctlw(1, 0, 0, 3, 0, 4, 2), 32'h02030500);
    frame_check("R6 lt true", 48, 1'b0, 4);
    clear_rules();
  endtask

  task automatic t_bases();
    rule(0, ctlw(1, 0, 0, 0, 1, 11, 0), 32'h450F1011);
    frame_check("R7 ip base", 48, 1'b0, 11);
    rule(0, ctlw(1, 0, 0, 0, 2, 12, 0), 32'h22232425);
    frame_check("R7 l4 base", 48, 1'b0, 12);
    rule(0, ctlw(1, 0, 0, 0, 3, 13, 2), 32'h02030405);
    frame_check("R7 sel3 frame", 48, 1'b0, 13);
    clear_rules();
  endtask

  task automatic t_chain();
    rule(0, ctlw(1, 1, 0, 0, 0, 7, 2), 32'h02030405);
    rule(1, ctlw(1, 0, 0, 0, 0, 8, 2), 32'h0);
    frame_check("R8 chain broken", 48, 1'b0, 9);
    rule(1, ctlw(1, 0, 0, 0, 0, 8, 6), 32'h06070809);
    frame_check("R8 chain whole", 48, 1'b0, 8);
    rule(1, ctlw(0, 0, 0, 0, 0, 8, 6), 32'h06070809);
    frame_check("R8 chain disabled member", 48, 1'b0, 9);
    clear_rules();
  endtask

  task automatic t_priority();
    rule(0, ctlw(1, 0, 0, 0, 0, 7, 2), 32'h02030405);
    rule(1, ctlw(1, 0, 0, 0, 0, 2, 6), 32'h06070809);
    frame_check("R9 low index wins", 48, 1'b0, 7);
    rule(0, ctlw(1, 0, 0, 0, 0, 7, 2), 32'h0);
    frame_check("R9 next rule", 48, 1'b0, 2);
    clear_rules();
  endtask

  task automatic t_trunc();
    rule(0, ctlw(1, 0, 0, 0, 0, 14, 46), 32'h2E2F0000);
    frame_check("R11 full window cut", 48, 1'b0, 9);
    rule(0, ctlw(1, 0, 1, 0, 0, 14, 46), 32'hFFFF_2E2F);
    frame_check("R11 short window fits", 48, 1'b0, 14);
    clear_rules();
  endtask

  task automatic t_bad_class();
    rule(0, ctlw(1, 0, 0, 0, 0, 0, 2), 32'h02030405);
    frame_check("R12 class zero", 48, 1'b1, 0);
    rule(0, ctlw(1, 0, 0, 0, 0, 20, 2), 32'h02030405);
    frame_check("R12 class 20", 48, 1'b1, 0);
    rule(0, ctlw(1, 0, 0, 0, 0, 16, 2), 32'h02030405);
    frame_check("R12 class 16", 48, 1'b0, 16);
    clear_rules();
  endtask

  initial begin
    for (int k = 0; k < 64; k++) fr[k] = 8'(k);
    fr[14] = 8'h45;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_default();
    t_full();
    t_disabled();
    t_masked();
    t_ops();
    t_bases();
    t_chain();
    t_priority();
    t_trunc();
    t_bad_class();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule